// File: doc/BRIEF.md
# Gated programmable clock divider

This block derives a slower clock enable from one of several source clock-enable streams. All of its logic runs on a single system clock. Each source arrives as a tick input that is high for one system-clock cycle per source-clock period. One 32-bit control word configures the block: a divide-minus-one field, a stop bit, and a source-select field. The width and position of the select field depend on how many sources the instance is built with.

The output `clk_en` is a registered level that repeats once per selected-source ticks equal to the divide ratio. It can drive a clock-enable tree or a gating cell downstream. Software writes the control word through a plain write strobe and reads it back one cycle later. A separate `enabled` output reports whether the divider is running.

The block avoids runt pulses when its settings change:
- A new ratio waits for the end of the current output period.
- A new source waits for a quiet window during which the output is held low.
- While stopped, the divider holds in a cleared state and reloads its ratio from the control word when it restarts.

Top module: `clkdiv_gate`

## Requirements
- R1: The divide ratio D equals control bits [5:0] plus one (1 to 64). One `clk_en` period spans D ticks of the selected source.
- R2: For D of 2 or more, `clk_en` is high for floor(D/2) source ticks and low for ceil(D/2) ticks. For D = 1, `clk_en` is held constantly high while running.
- R3: Control bit 8 is the stop bit. When it is 1, `clk_en` is held low from the next cycle onward. When it is 0, the divider runs.
- R4: A write with bit 8 set and bits [5:0] equal to zero stores 6'h3F in the divide field.
- R5: `enabled` and read-back bit 8 reflect the stop bit: `enabled` is 1 exactly when bit 8 is 0.
- R6: The source index sits in bits [14:12] when there are eight sources and in bits [7:6] when there are four. A single-source build has no select field.
- R7: A divide change written while running takes effect only when the current output period ends. The high phase in progress completes at the old length.
- R8: After a change of source index, `clk_en` stays low for at least HOLD_CYC cycles. The divider then restarts from the beginning of a period on the new source.
- R9: After reset, the read-back word is 0x0000_013F: divide field all ones, stop set, source 0. `enabled` and `clk_en` are 0.
- R10: Bits that belong to no field read back as 0, whatever was written to them.
- R11: While stopped, divide writes do not produce output. On re-enable, the ratio is the one held in the divide field at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Registered read-back of the control word |
| src_tick | input | NSRC | One tick per cycle of each source clock |
| clk_en | output | 1 | Divided, gated clock-enable level |
| enabled | output | 1 | High when the stop bit is clear |

## Verification
The main instance is built with eight sources and HOLD_CYC = 4. Source 0 ticks every cycle, so each output period is exactly D system cycles and the duty and ratio counts are exact. The slower sources make a switch to a different source rate observable.

A second instance with four sources receives the same writes. It shows the select field landing at bits [7:6] and the unassigned-bit masking for that layout. The single-source layout is reached only by elaboration with its default-free branch.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W    = 32;
  localparam int DIV_W    = 6;
  localparam int RATIO_W  = DIV_W + 1;
  localparam int STOP_BIT = 8;

  function automatic int sel_lsb(input int nsrc);
    return (nsrc == 8) ? 12 : ((nsrc == 4) ? 6 : 0);
  endfunction

  function automatic int sel_w(input int nsrc);
    return (nsrc == 8) ? 3 : ((nsrc == 4) ? 2 : 0);
  endfunction

  function automatic logic [REG_W-1:0] reg_mask(input int nsrc);
    logic [REG_W-1:0] m;
    m = 32'h0000_013F;
    for (int b = 0; b < REG_W; b++)
      if (b >= sel_lsb(nsrc) && b < sel_lsb(nsrc) + sel_w(nsrc)) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [DIV_W-1:0] f);
    return {1'b0, f} + RATIO_W'(1);
  endfunction

  // high for the last floor(D/2) counts of a period; D == 1 is always high
  function automatic logic phase_high(input logic [DIV_W-1:0] cnt,
                                      input logic [RATIO_W-1:0] ratio);
    if (ratio == RATIO_W'(1)) return 1'b1;
    return {1'b0, cnt} >= (ratio - (ratio >> 1));
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [DIV_W-1:0] cfg_div,
  output logic             cfg_stop,
  output logic [IDX_W-1:0] cfg_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             enabled
);
  localparam int SEL_LSB = sel_lsb(NSRC);
  localparam int SEL_W   = sel_w(NSRC);

  logic [IDX_W-1:0] sel_in;
  logic [REG_W-1:0] sel_img;
  logic [REG_W-1:0] img;
  logic [DIV_W-1:0] div_in;

  generate
    if (SEL_W > 0) begin : g_sel
      assign sel_in  = wr_data[SEL_LSB +: SEL_W];
      assign sel_img = REG_W'(cfg_sel) << SEL_LSB;
    end else begin : g_nosel
      assign sel_in  = '0;
      assign sel_img = '0;
    end
  endgenerate

  // stopping needs a non-zero divide field
  assign div_in = (wr_data[STOP_BIT] && wr_data[DIV_W-1:0] == '0)
                  ? {DIV_W{1'b1}} : wr_data[DIV_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div  <= {DIV_W{1'b1}};
      cfg_stop <= 1'b1;
      cfg_sel  <= '0;
    end else if (wr_en) begin
      cfg_div  <= div_in;
      cfg_stop <= wr_data[STOP_BIT];
      cfg_sel  <= sel_in;
    end
  end

  always_comb begin
    img                = sel_img;
    img[DIV_W-1:0]     = cfg_div;
    img[STOP_BIT]      = cfg_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 32'h0000_013F;
      enabled <= 1'b0;
    end else begin
      rd_data <= img;
      enabled <= ~cfg_stop;
    end
  end
endmodule

// File: rtl/clkdiv_srcsel.sv
module clkdiv_srcsel #(
  parameter int NSRC     = 8,
  parameter int HOLD_CYC = 4,
  parameter int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cfg_sel,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick,
  output logic             hold
);
  localparam int QW = $clog2(HOLD_CYC + 1);

  logic [IDX_W-1:0] act_q;
  logic             quiet_q;
  logic [QW-1:0]    qcnt_q;
  logic             picked;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      quiet_q <= 1'b0;
      qcnt_q  <= '0;
    end else if (!quiet_q) begin
      if (act_q != cfg_sel) begin
        quiet_q <= 1'b1;
        qcnt_q  <= '0;
      end
    end else if (qcnt_q == QW'(HOLD_CYC - 1)) begin
      quiet_q <= 1'b0;
      act_q   <= cfg_sel;
    end else begin
      qcnt_q <= qcnt_q + QW'(1);
    end
  end

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (act_q == IDX_W'(i)) picked = src_tick[i];
  end

  assign hold = quiet_q || (act_q != cfg_sel);
  assign tick = !hold && picked;
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             clk_en
);
  logic [DIV_W-1:0]   cnt_q, cnt_n;
  logic [RATIO_W-1:0] div_q, div_n;

  always_comb begin
    cnt_n = cnt_q;
    div_n = div_q;
    if (!run) begin
      cnt_n = '0;
      div_n = ratio_of(cfg_div);
    end else if (tick) begin
      if ({1'b0, cnt_q} == div_q - RATIO_W'(1)) begin
        cnt_n = '0;
        div_n = ratio_of(cfg_div);
      end else begin
        cnt_n = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      div_q  <= RATIO_W'(64);
      clk_en <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      div_q  <= div_n;
      clk_en <= run && phase_high(cnt_n, div_n);
    end
  end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import clkdiv_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [NSRC-1:0]  src_tick,
  output logic             clk_en,
  output logic             enabled
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_stop;
  logic [IDX_W-1:0] cfg_sel;
  logic             sel_tick;
  logic             sel_hold;

  clkdiv_regs #(.NSRC(NSRC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_div(cfg_div), .cfg_stop(cfg_stop), .cfg_sel(cfg_sel),
    .rd_data(rd_data), .enabled(enabled)
  );

  clkdiv_srcsel #(.NSRC(NSRC), .HOLD_CYC(HOLD_CYC), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .src_tick(src_tick),
    .tick(sel_tick), .hold(sel_hold)
  );

  clkdiv_counter u_div (
    .clk(clk), .rst(rst), .run(!cfg_stop && !sel_hold), .tick(sel_tick),
    .cfg_div(cfg_div), .clk_en(clk_en)
  );
endmodule

// File: rtl/clkdiv_gate_chk.sv
module clkdiv_gate_chk
  import clkdiv_pkg::*;
#(
  parameter int NSRC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        clk_en,
  input logic        enabled,
  input logic        cfg_stop,
  input logic [5:0]  cfg_div,
  input logic        sel_hold
);
  localparam logic [31:0] MASK = reg_mask(NSRC);

  // R3
  stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_stop |=> !clk_en);

  // R4
  stop_div_nz_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[8]) |=> (cfg_div != 6'd0));

  // R5
  enable_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enabled) |-> $past(wr_en && !wr_data[8], 2));

  // R8
  switch_low_chk: assert property (@(posedge clk) disable iff (rst)
    sel_hold |=> !clk_en);

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~MASK) == 32'd0);
endmodule

bind clkdiv_gate clkdiv_gate_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .clk_en(clk_en), .enabled(enabled), .cfg_stop(cfg_stop), .cfg_div(cfg_div),
  .sel_hold(sel_hold)
);

// File: tb/clkdiv_gate_tb.sv
module clkdiv_gate_tb;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  src = 8'h01;
  logic [31:0] rd_data, rd4;
  logic        clk_en, enabled, clk_en4, enabled4;
  int          n_chk = 0;
  int          n_bad = 0;
  int          phase = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  clkdiv_gate #(.NSRC(8), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_tick(src), .clk_en(clk_en), .enabled(enabled)
  );

  clkdiv_gate #(.NSRC(4), .HOLD_CYC(HOLD)) u_dut4 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd4),
    .src_tick(src[3:0]), .clk_en(clk_en4), .enabled(enabled4)
  );

  // source k ticks once every k+1 system cycles
  always @(negedge clk) begin
    phase <= phase + 1;
    for (int k = 1; k < 8; k++) src[k] <= ((phase + 1) % (k + 1)) == 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_window(input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0; prev = clk_en;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en) highs++;
      if (clk_en && !prev) rises++;
      prev = clk_en;
    end
  endtask

  task automatic t_reset();
    check("R9 read-back", rd_data, 32'h0000_013F);
    check("R9 enabled", {31'd0, enabled}, 32'd0);
    check("R9 clk_en", {31'd0, clk_en}, 32'd0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 R6 eight-source read-back", rd_data, 32'h0000_713F);
    check("R10 R6 four-source read-back", rd4, 32'h0000_01FF);
    wr(32'h0000_0100);
    @(negedge clk);
    check("R4 stop with zero divide", rd_data, 32'h0000_013F);
    check("R5 enabled while stopped", {31'd0, enabled}, 32'd0);
  endtask

  task automatic t_stopped();
    int lows;
    wr(32'h0000_0104);
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!clk_en) lows++;
    end
    check("R3 R11 output held while stopped", lows, 100);
    wr(32'h0000_0004);
    @(negedge clk);
    check("R5 enabled after run write", {31'd0, enabled}, 32'd1);
  endtask

  task automatic t_ratio(input int d);
    int h, r;
    wr(32'(d - 1));
    repeat (140) @(negedge clk);
    count_window(16 * d, h, r);
    check($sformatf("R1 R2 high cycles D=%0d", d), h, (d == 1) ? 16 : 16 * (d / 2));
    if (d > 1) check($sformatf("R1 periods D=%0d", d), r, 16);
  endtask

  task automatic t_runt();
    int hl, ll, hl2;
    logic prev;
    wr(32'd7);
    repeat (40) @(negedge clk);
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (clk_en && !prev) break;
      prev = clk_en;
    end
    wr_en = 1'b1;
    wr_data = 32'd1;
    hl = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (clk_en) begin hl++; @(negedge clk); end
    ll = 0;
    while (!clk_en) begin ll++; @(negedge clk); end
    hl2 = 0;
    while (clk_en) begin hl2++; @(negedge clk); end
    check("R7 high phase completes at old ratio", hl, 4);
    check("R7 new ratio low phase", ll, 1);
    check("R7 new ratio high phase", hl2, 1);
  endtask

  task automatic t_switch();
    int lows, h, r;
    wr(32'd1);
    repeat (20) @(negedge clk);
    wr(32'h0000_1001);
    lows = 0;
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      if (!clk_en) lows++;
    end
    check("R8 low during source handover", lows, HOLD);
    repeat (20) @(negedge clk);
    count_window(256, h, r);
    check("R8 high cycles on source 1", h, 128);
    check("R8 periods on source 1", r, 64);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_stopped();
    t_ratio(5);
    t_ratio(1);
    t_ratio(2);
    t_ratio(3);
    t_ratio(64);
    t_runt();
    t_switch();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule